// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the device side of a parallel NOR flash and interprets the stream of host write cycles. Each write carries a 20-bit address and a 32-bit data word. The block matches the unlock-and-command sequences used by this class of flash and keeps track of the current operating mode. When a sequence completes, it raises a single-cycle request towards an external program/erase engine. The engine itself is not part of this block. It reports back through two inputs: a busy flag, and a flag that says a sector erase is running.

Most commands start with two unlock writes: low byte AA at low address 555, then 55 at 2AA. The third write carries the command code. An unlock-bypass mode drops the unlock writes so that repeated programming is shorter. A suspended erase is tracked apart from the mode, so that the read and autoselect modes can still be used while an erase is on hold. The request outputs come from registers. Each request is high in the clock cycle that follows the write which completes its sequence.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode` is 0 (read) and every request output is 0.
- R2: The program sequence is AA at 555, 55 at 2AA, A0 at 555, then any write. The last write makes `req_program` high for one cycle, with `req_addr` and `req_data` equal to that write's address and data.
- R3: Sequence matching looks only at address bits 10:0 and data bits 7:0. Bits 19:11 of the address and bits 31:8 of the data have no effect.
- R4: The erase prefix is AA at 555, 55 at 2AA, 80 at 555, AA at 555, 55 at 2AA. A sixth write of 10 at 555 pulses `req_chip_erase`. A sixth write of 30 at any address pulses `req_sector_erase`, and `req_addr` then holds that address.
- R5: After the two unlock writes, 90 at 555 sets `mode` to 1 (autoselect). In read or autoselect mode, a single write of 98 at 055 sets `mode` to 2 (CFI). F0 at any address returns to read mode.
- R6: A write that does not fit the next step of a partial sequence abandons that sequence. It does not change `mode` and raises no request. `mode` changes only on an accepted write.
- R7: B0 at any address pulses `req_suspend` only while `erase_active` is 1 and no erase is already suspended. `mode` then reads 4 (erase-suspend). While suspended, autoselect can still be entered, and F0 then returns `mode` to 4. In mode 4, 30 pulses `req_resume` and returns `mode` to 0. At any other time, 30 is ignored.
- R8: After the two unlock writes, 20 at 555 enters unlock-bypass (`mode` 3). In that mode, A0 followed by any write pulses `req_program`, and 80 followed by 10 pulses `req_chip_erase`. Neither sequence needs unlock writes.
- R9: In unlock-bypass, 98 sets `mode` to 5 (CFI entered from bypass), and F0 then returns `mode` to 3. Writing 90 and then 00 at any addresses sets `mode` to 0. Writing 90 followed by any other value leaves `mode` at 3.
- R10: After the two unlock writes, D0 at 555 followed by one data write pulses `req_cfg_write`. The sequence is ignored if `eng_busy` is 1 or an erase is suspended.
- R11: A request output never stays high for two cycles in a row, and at most one request output is high at a time.
- R12: While `eng_busy` is 1, program and erase sequences raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A host write cycle is present this clock |
| wr_addr | input | 20 | Write address; bits 19:18 select the bank |
| wr_data | input | 32 | Write data |
| eng_busy | input | 1 | Embedded program/erase engine is busy |
| erase_active | input | 1 | A sector erase is running in the engine |
| mode | output | 3 | 0 read, 1 autoselect, 2 CFI, 3 unlock-bypass, 4 erase-suspend, 5 CFI from bypass |
| req_program | output | 1 | One-cycle program request |
| req_chip_erase | output | 1 | One-cycle chip-erase request |
| req_sector_erase | output | 1 | One-cycle sector-erase request |
| req_suspend | output | 1 | One-cycle erase-suspend request |
| req_resume | output | 1 | One-cycle erase-resume request |
| req_cfg_write | output | 1 | One-cycle configuration-register write request |
| req_addr | output | 20 | Address of the last accepted write |
| req_data | output | 32 | Data of the last accepted write |

## Verification
The hardest state to reach from the ports is a suspended erase with autoselect entered inside it. Reaching it needs the engine flags held in a particular combination, a suspend write, a full unlock sequence, and then a reset command whose outcome depends on the hidden suspend flag. The stimulus drives `erase_active` high by hand to stand in for the engine, and walks through suspend, autoselect, F0 and resume in order. It checks `mode` after each step, and then tries a configuration write and a second resume that must both be dropped. Random writes whose low bytes avoid every command code are mixed in to show that stray traffic never moves the mode.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          eng_busy,
  input  logic          erase_active,
  output logic [2:0]    mode,
  output logic          req_program,
  output logic          req_chip_erase,
  output logic          req_sector_erase,
  output logic          req_suspend,
  output logic          req_resume,
  output logic          req_cfg_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  localparam logic [2:0] M_READ = 3'd0, M_ASEL = 3'd1, M_CFI = 3'd2,
                         M_BYP = 3'd3, M_SUSP = 3'd4, M_BCFI = 3'd5;
  localparam logic [10:0] A_555 = 11'h555, A_2AA = 11'h2AA, A_055 = 11'h055;

  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PROG, S_E1, S_E2, S_E3, S_CFG, S_BX, S_BPROG, S_BERASE
  } st_t;

  st_t        st;
  logic [2:0] m;
  logic       susp;

  wire [10:0] la   = wr_addr[10:0];
  wire [7:0]  ld   = wr_data[7:0];
  wire        is_unl1 = (la == A_555) && (ld == 8'hAA);
  wire        is_unl2 = (la == A_2AA) && (ld == 8'h55);
  wire        can_op  = !eng_busy;
  wire        can_cfg = !eng_busy && !susp;

  assign mode = (m == M_READ && susp) ? M_SUSP : m;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      m <= M_READ;
      susp <= 1'b0;
      req_program <= 1'b0;
      req_chip_erase <= 1'b0;
      req_sector_erase <= 1'b0;
      req_suspend <= 1'b0;
      req_resume <= 1'b0;
      req_cfg_write <= 1'b0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      req_program <= 1'b0;
      req_chip_erase <= 1'b0;
      req_sector_erase <= 1'b0;
      req_suspend <= 1'b0;
      req_resume <= 1'b0;
      req_cfg_write <= 1'b0;
      if (wr_valid) begin
        req_addr <= wr_addr;
        req_data <= wr_data;
        st <= S_IDLE;
        case (st)
          S_IDLE:
            if (m == M_BYP) begin
              case (ld)
                8'hA0: if (can_op) st <= S_BPROG;
                8'h80: if (can_op) st <= S_BERASE;
                8'h98: m <= M_BCFI;
                8'h90: st <= S_BX;
                default: ;
              endcase
            end else if (ld == 8'hF0) begin
              m <= (m == M_BCFI) ? M_BYP : M_READ;
            end else if (is_unl1 && m != M_BCFI) begin
              st <= S_U1;
            end else if (ld == 8'h98 && la == A_055 && (m == M_READ || m == M_ASEL)) begin
              m <= M_CFI;
            end else if (ld == 8'hB0 && erase_active && !susp) begin
              susp <= 1'b1;
              m <= M_READ;
              req_suspend <= 1'b1;
            end else if (ld == 8'h30 && susp && m == M_READ) begin
              susp <= 1'b0;
              req_resume <= 1'b1;
            end
          S_U1: if (is_unl2) st <= S_U2;
          S_U2:
            if (la == A_555) begin
              case (ld)
                8'h90: m <= M_ASEL;
                8'h20: if (!susp) m <= M_BYP;
                8'hA0: if (can_op) st <= S_PROG;
                8'h80: if (can_op && !susp) st <= S_E1;
                8'hD0: if (can_cfg) st <= S_CFG;
                default: ;
              endcase
            end
          S_PROG: req_program <= 1'b1;
          S_E1: if (is_unl1) st <= S_E2;
          S_E2: if (is_unl2) st <= S_E3;
          S_E3:
            if (ld == 8'h10 && la == A_555) req_chip_erase <= 1'b1;
            else if (ld == 8'h30) req_sector_erase <= 1'b1;
          S_CFG: if (can_cfg) req_cfg_write <= 1'b1;
          S_BX: if (ld == 8'h00) m <= M_READ;
          S_BPROG: req_program <= 1'b1;
          S_BERASE: if (ld == 8'h10) req_chip_erase <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       eng_busy,
  input logic       erase_active,
  input logic [2:0] mode,
  input logic       req_program,
  input logic       req_chip_erase,
  input logic       req_sector_erase,
  input logic       req_suspend,
  input logic       req_resume,
  input logic       req_cfg_write
);
  wire [5:0] reqs = {req_program, req_chip_erase, req_sector_erase,
                     req_suspend, req_resume, req_cfg_write};

  a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reqs));
  a_r11_prog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_program |=> !req_program);
  a_r11_susp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend |=> !req_suspend);
  a_r6_req_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reqs != 6'd0) |-> $past(wr_valid));
  a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> $stable(mode));
  a_r7_susp_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend |-> ($past(erase_active) && mode == 3'd4));
  a_r7_resume_gated: assert property (@(posedge clk) disable iff (!rst_n)
    req_resume |-> ($past(mode) == 3'd4 && mode == 3'd0));
  a_r10_cfg_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_cfg_write |-> !$past(eng_busy));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk u_chk (.*);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  logic clk = 0, rst_n = 0, wr_valid = 0, eng_busy = 0, erase_active = 0;
  logic [19:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] mode;
  logic req_program, req_chip_erase, req_sector_erase, req_suspend, req_resume, req_cfg_write;
  logic [19:0] req_addr;
  logic [31:0] req_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_cmd_seq u_flash_cmd_seq (.*);

  wire [5:0] reqv = {req_program, req_chip_erase, req_sector_erase,
                     req_suspend, req_resume, req_cfg_write};
  localparam logic [5:0] Q_NONE = 6'd0, Q_PROG = 6'b100000, Q_CHIP = 6'b010000,
    Q_SECT = 6'b001000, Q_SUSP = 6'b000100, Q_RES = 6'b000010, Q_CFG = 6'b000001;

  function automatic bit is_code(logic [7:0] b);
    return b == 8'hAA || b == 8'hF0 || b == 8'h98 || b == 8'hB0 || b == 8'h30;
  endfunction

  function automatic logic [7:0] safe_byte(logic [7:0] seed);
    logic [7:0] b = seed;
    while (is_code(b)) b = b + 8'd1;
    return b;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [19:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic unlock();
    wr(20'h00555, 32'h0000_00AA);
    wr(20'h002AA, 32'h0000_0055);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset mode", {29'd0, mode}, 0);
    chk("R1 reset reqs", {26'd0, reqv}, 0);
    rst_n = 1;
    @(negedge clk);

    unlock(); wr(20'h00555, 32'hA0);
    wr(20'h12345, 32'hDEAD_BEEF);
    chk("R2 program req", {26'd0, reqv}, {26'd0, Q_PROG});
    chk("R2 program addr", {12'd0, req_addr}, 32'h12345);
    chk("R2 program data", req_data, 32'hDEAD_BEEF);
    @(negedge clk);
    chk("R11 program pulse ends", {26'd0, reqv}, 0);

    wr(20'hFF555, 32'hABCD_00AA); wr(20'h3A2AA, 32'h1234_5655);
    wr(20'hC0555, 32'h7777_77A0); wr(20'h00042, 32'h42);
    chk("R3 high bits ignored", {26'd0, reqv}, {26'd0, Q_PROG});

    unlock(); wr(20'h00555, 32'h80); unlock(); wr(20'h00555, 32'h10);
    chk("R4 chip erase", {26'd0, reqv}, {26'd0, Q_CHIP});
    unlock(); wr(20'h00555, 32'h80); unlock(); wr(20'h4A800, 32'h30);
    chk("R4 sector erase", {26'd0, reqv}, {26'd0, Q_SECT});
    chk("R4 sector addr", {12'd0, req_addr}, 32'h4A800);

    unlock(); wr(20'h40555, 32'h90);
    chk("R5 autoselect", {29'd0, mode}, 1);
    wr(20'h00000, 32'hF0);
    chk("R5 reset to read", {29'd0, mode}, 0);
    wr(20'h00055, 32'h98);
    chk("R5 cfi", {29'd0, mode}, 2);
    wr(20'h00123, 32'hF0);
    chk("R5 cfi exit", {29'd0, mode}, 0);

    unlock(); wr(20'h00555, 32'h77);
    chk("R6 bad command no mode change", {29'd0, mode}, 0);
    wr(20'h00100, 32'h11);
    chk("R6 abandoned no req", {26'd0, reqv}, 0);
    wr(20'h00555, 32'hAA); wr(20'h002AB, 32'h55); wr(20'h00555, 32'h90);
    chk("R6 wrong unlock address", {29'd0, mode}, 0);
    for (int i = 0; i < 150; i++) begin
      logic [31:0] r = $urandom;
      wr(r[19:0], {r[31:8], safe_byte(r[7:0])});
      if (mode !== 3'd0 || reqv !== 6'd0)
        chk("R6 random write", {26'd0, reqv, 1'b0, mode}, 0);
      else checks++;
    end

    wr(20'h80000, 32'hB0);
    chk("R7 suspend needs erase", {26'd0, reqv}, 0);
    erase_active = 1;
    wr(20'h80000, 32'hB0);
    chk("R7 suspend req", {26'd0, reqv}, {26'd0, Q_SUSP});
    chk("R7 suspend mode", {29'd0, mode}, 4);
    erase_active = 0;
    unlock(); wr(20'h80555, 32'h90);
    chk("R7 autoselect in suspend", {29'd0, mode}, 1);
    wr(20'h00000, 32'hF0);
    chk("R7 F0 back to suspend", {29'd0, mode}, 4);
    unlock(); wr(20'h00555, 32'hD0); wr(20'h00000, 32'h5);
    chk("R10 cfg ignored in suspend", {26'd0, reqv}, 0);
    wr(20'h80000, 32'h30);
    chk("R7 resume req", {26'd0, reqv}, {26'd0, Q_RES});
    chk("R7 resume mode", {29'd0, mode}, 0);
    wr(20'h80000, 32'h30);
    chk("R7 resume ignored", {26'd0, reqv}, 0);

    eng_busy = 1;
    unlock(); wr(20'h00555, 32'hD0); wr(20'h00000, 32'h5);
    chk("R10 cfg ignored busy", {26'd0, reqv}, 0);
    unlock(); wr(20'h00555, 32'hA0); wr(20'h00010, 32'h9);
    chk("R12 program ignored busy", {26'd0, reqv}, 0);
    eng_busy = 0;
    unlock(); wr(20'h00555, 32'hD0); wr(20'h00000, 32'hC3);
    chk("R10 cfg write", {26'd0, reqv}, {26'd0, Q_CFG});
    chk("R10 cfg data", req_data, 32'hC3);

    unlock(); wr(20'h00555, 32'h20);
    chk("R8 bypass entry", {29'd0, mode}, 3);
    wr(20'h00000, 32'hA0); wr(20'h0ABCD, 32'h55AA);
    chk("R8 bypass program", {26'd0, reqv}, {26'd0, Q_PROG});
    chk("R8 bypass program addr", {12'd0, req_addr}, 32'h0ABCD);
    wr(20'h00000, 32'h80); wr(20'h00000, 32'h10);
    chk("R8 bypass chip erase", {26'd0, reqv}, {26'd0, Q_CHIP});
    chk("R8 bypass mode kept", {29'd0, mode}, 3);
    wr(20'h00000, 32'h98);
    chk("R9 bypass cfi", {29'd0, mode}, 5);
    wr(20'h00000, 32'hF0);
    chk("R9 cfi back to bypass", {29'd0, mode}, 3);
    wr(20'h00000, 32'h90); wr(20'h00000, 32'h55);
    chk("R9 bad exit stays bypass", {29'd0, mode}, 3);
    wr(20'h00000, 32'h90); wr(20'h00000, 32'h00);
    chk("R9 bypass exit", {29'd0, mode}, 0);

    finish_run();
  end
endmodule